// File: doc/BRIEF.md
# Energy-Indexed Loss Threshold Comparator

This block decides whether the beam must be dumped. It receives twelve running loss sums for each of sixteen detector channels and a 5-bit beam-energy level. Each sum is compared against a limit held in a table indexed by channel, sum index and energy level. When any sum is strictly above its limit, the block raises a single dump-request line. The line stays high until it is cleared. Alongside it, the block reports which channel and which sum index tripped first.

The threshold table is a simple dual-port RAM that block RAM can hold. A write port loads it, and a scan engine reads it. The scan visits one (channel, sum) pair per clock, so each sum is compared once every 192 cycles. The read always uses the energy level in force at that moment. A change of level restarts the scan at channel 0, sum 0. Any threshold still in flight from the old level is thrown away.

Top module: `elvl_thr_cmp`

## Requirements
- R1: A write with `tw_en_i` high stores `tw_data_i` as the threshold for (`tw_ch_i`, `tw_rs_i`, `tw_lvl_i`). A write whose sum index is 12 or more, or whose channel is out of range, changes no threshold.
- R2: A sum raises the request only when it is strictly greater than its threshold. A sum equal to its threshold does not.
- R3: The threshold used is the one stored for the energy level present on `lvl_i`. Thresholds stored for other levels have no effect.
- R4: The sum for channel c and index r sits at bits [(c*12+r)*SUM_W +: SUM_W] of `sums_i`, with SUM_W = 20. Every pair from (0,0) to (15,11) is compared.
- R5: With the level held steady, a violating sum raises `dump_o` within 2*192+4 cycles.
- R6: `dump_o` stays high once set until `clear_i` is high at a clock edge. After that edge it is low. Clear takes priority over a violation found at the same edge.
- R7: `viol_ch_o` and `viol_rs_o` hold the channel and sum index of the first violation found since reset or the last clear. They do not change while `dump_o` stays high.
- R8: A change of `lvl_i` restarts the scan at channel 0, sum 0. No request is raised from a threshold read under the previous level, including a read already in flight.
- R9: After reset, `dump_o`, `viol_ch_o` and `viol_rs_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sums_i | input | 3840 | Packed running sums, 192 fields of 20 bits |
| lvl_i | input | 5 | Present beam-energy level |
| clear_i | input | 1 | Clears the sticky request |
| tw_en_i | input | 1 | Threshold write enable |
| tw_ch_i | input | 4 | Channel of the threshold write |
| tw_rs_i | input | 4 | Sum index of the threshold write |
| tw_lvl_i | input | 5 | Energy level of the threshold write |
| tw_data_i | input | 20 | Threshold value to write |
| dump_o | output | 1 | Sticky beam-dump request |
| viol_ch_o | output | 4 | Channel of the first violation |
| viol_rs_o | output | 4 | Sum index of the first violation |

## Verification
The bench sets each sum equal to its threshold and then one above it. A design that compares with greater-or-equal dumps one step too early. It also drives a one-cycle energy-level pulse to a level whose threshold would violate. A design that keeps using the read already in flight raises a false request from the discarded level. Two sums are made to violate at the same time after a level change. If the scan does not restart, or if the captured indices can be overwritten, a different pair is reported. A write with sum index 13 is aimed at an aliasing slot; a design without the range guard would corrupt a neighbour's limit. The pairs at both ends of the packed vector are checked so that an off-by-one in the slicing shows up.

// File: rtl/elvl_pkg.sv
package elvl_pkg;

  localparam int DEF_N_CH  = 16;
  localparam int DEF_N_RS  = 12;
  localparam int DEF_N_LVL = 32;
  localparam int DEF_SUM_W = 20;

  // Linear slot of a (channel, sum) pair, channel-major.
  function automatic int slot_of(input int ch, input int rs, input int n_rs);
    return ch * n_rs + rs;
  endfunction

endpackage

// File: rtl/elvl_thr_ram.sv
module elvl_thr_ram #(
  parameter int DW    = 20,
  parameter int DEPTH = 6144,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/elvl_scan_ctrl.sv
module elvl_scan_ctrl #(
  parameter int N_CH  = 16,
  parameter int N_RS  = 12,
  parameter int N_LVL = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int RS_W   = $clog2(N_RS),
  localparam int LVL_W  = $clog2(N_LVL),
  localparam int N_SLOT = N_CH * N_RS,
  localparam int SLOT_W = $clog2(N_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [LVL_W-1:0]  rd_lvl_o,
  output logic              lvl_chg_o,
  output logic              tag_vld_o,
  output logic [SLOT_W-1:0] tag_slot_o,
  output logic [CH_W-1:0]   tag_ch_o,
  output logic [RS_W-1:0]   tag_rs_o
);

  logic [CH_W-1:0]   ch_q;
  logic [RS_W-1:0]   rs_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              rs_last;
  logic              ch_last;

  assign lvl_chg_o = (lvl_i != lvl_q);
  assign rs_last   = (rs_q == RS_W'(N_RS - 1));
  assign ch_last   = (ch_q == CH_W'(N_CH - 1));
  assign rd_slot_o = slot_q;
  assign rd_lvl_o  = lvl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ch_q       <= '0;
      rs_q       <= '0;
      slot_q     <= '0;
      lvl_q      <= '0;
      tag_vld_o  <= 1'b0;
      tag_slot_o <= '0;
      tag_ch_o   <= '0;
      tag_rs_o   <= '0;
    end else if (lvl_chg_o) begin
      // restart under the new level, drop the read issued this edge
      lvl_q     <= lvl_i;
      ch_q      <= '0;
      rs_q      <= '0;
      slot_q    <= '0;
      tag_vld_o <= 1'b0;
    end else begin
      tag_vld_o  <= 1'b1;
      tag_slot_o <= slot_q;
      tag_ch_o   <= ch_q;
      tag_rs_o   <= rs_q;
      if (rs_last) begin
        rs_q <= '0;
        if (ch_last) begin
          ch_q   <= '0;
          slot_q <= '0;
        end else begin
          ch_q   <= ch_q + 1'b1;
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        rs_q   <= rs_q + 1'b1;
        slot_q <= slot_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/elvl_cmp.sv
module elvl_cmp #(
  parameter int N_CH  = 16,
  parameter int N_RS  = 12,
  parameter int SUM_W = 20,
  localparam int N_SLOT = N_CH * N_RS,
  localparam int SLOT_W = $clog2(N_SLOT)
) (
  input  logic [N_SLOT*SUM_W-1:0] sums_i,
  input  logic [SLOT_W-1:0]       tag_slot_i,
  input  logic                    tag_vld_i,
  input  logic                    lvl_chg_i,
  input  logic [SUM_W-1:0]        thr_i,
  output logic                    hit_o
);

  logic [SUM_W-1:0] cur_sum;

  assign cur_sum = sums_i[int'(tag_slot_i) * SUM_W +: SUM_W];
  assign hit_o   = tag_vld_i && !lvl_chg_i && (cur_sum > thr_i);

endmodule

// File: rtl/elvl_thr_cmp.sv
module elvl_thr_cmp #(
  parameter int N_CH  = elvl_pkg::DEF_N_CH,
  parameter int N_RS  = elvl_pkg::DEF_N_RS,
  parameter int N_LVL = elvl_pkg::DEF_N_LVL,
  parameter int SUM_W = elvl_pkg::DEF_SUM_W,
  localparam int CH_W   = $clog2(N_CH),
  localparam int RS_W   = $clog2(N_RS),
  localparam int LVL_W  = $clog2(N_LVL),
  localparam int N_SLOT = N_CH * N_RS,
  localparam int SLOT_W = $clog2(N_SLOT),
  localparam int DEPTH  = N_SLOT * N_LVL,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [N_SLOT*SUM_W-1:0] sums_i,
  input  logic [LVL_W-1:0]        lvl_i,
  input  logic                    clear_i,
  input  logic                    tw_en_i,
  input  logic [CH_W-1:0]         tw_ch_i,
  input  logic [RS_W-1:0]         tw_rs_i,
  input  logic [LVL_W-1:0]        tw_lvl_i,
  input  logic [SUM_W-1:0]        tw_data_i,
  output logic                    dump_o,
  output logic [CH_W-1:0]         viol_ch_o,
  output logic [RS_W-1:0]         viol_rs_o
);

  logic              wr_ok;
  logic [AW-1:0]     waddr;
  logic [AW-1:0]     raddr;
  logic [SUM_W-1:0]  thr;
  logic [SLOT_W-1:0] rd_slot;
  logic [LVL_W-1:0]  rd_lvl;
  logic              lvl_chg;
  logic              tag_vld;
  logic [SLOT_W-1:0] tag_slot;
  logic [CH_W-1:0]   tag_ch;
  logic [RS_W-1:0]   tag_rs;
  logic              hit;

  // out-of-range writes would alias onto a neighbour's slot
  assign wr_ok = tw_en_i && (int'(tw_ch_i) < N_CH) && (int'(tw_rs_i) < N_RS);
  assign waddr = AW'(elvl_pkg::slot_of(int'(tw_ch_i), int'(tw_rs_i), N_RS) * N_LVL
                     + int'(tw_lvl_i));
  assign raddr = AW'(int'(rd_slot) * N_LVL + int'(rd_lvl));

  elvl_thr_ram #(.DW(SUM_W), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (waddr),
    .wdata_i (tw_data_i),
    .raddr_i (raddr),
    .rdata_o (thr)
  );

  elvl_scan_ctrl #(.N_CH(N_CH), .N_RS(N_RS), .N_LVL(N_LVL)) u_scan (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .lvl_i      (lvl_i),
    .rd_slot_o  (rd_slot),
    .rd_lvl_o   (rd_lvl),
    .lvl_chg_o  (lvl_chg),
    .tag_vld_o  (tag_vld),
    .tag_slot_o (tag_slot),
    .tag_ch_o   (tag_ch),
    .tag_rs_o   (tag_rs)
  );

  elvl_cmp #(.N_CH(N_CH), .N_RS(N_RS), .SUM_W(SUM_W)) u_cmp (
    .sums_i     (sums_i),
    .tag_slot_i (tag_slot),
    .tag_vld_i  (tag_vld),
    .lvl_chg_i  (lvl_chg),
    .thr_i      (thr),
    .hit_o      (hit)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dump_o    <= 1'b0;
      viol_ch_o <= '0;
      viol_rs_o <= '0;
    end else if (clear_i) begin
      dump_o <= 1'b0;
    end else if (hit && !dump_o) begin
      dump_o    <= 1'b1;
      viol_ch_o <= tag_ch;
      viol_rs_o <= tag_rs;
    end
  end

endmodule

// File: rtl/elvl_thr_cmp_chk.sv
module elvl_thr_cmp_chk #(
  parameter int N_CH  = 16,
  parameter int N_RS  = 12,
  parameter int CH_W  = 4,
  parameter int RS_W  = 4,
  parameter int LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             clear_i,
  input logic [LVL_W-1:0] lvl_i,
  input logic             dump_o,
  input logic [CH_W-1:0]  viol_ch_o,
  input logic [RS_W-1:0]  viol_rs_o
);

  logic [LVL_W-1:0] prev_lvl;
  logic             prev_ok;
  logic             chg;
  logic             chg_d;

  assign chg = prev_ok && (lvl_i != prev_lvl);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_ok  <= 1'b0;
      prev_lvl <= '0;
      chg_d    <= 1'b0;
    end else begin
      prev_ok  <= 1'b1;
      prev_lvl <= lvl_i;
      chg_d    <= chg;
    end
  end

  AST_DUMP_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (dump_o && !clear_i) |=> dump_o); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    clear_i |=> !dump_o); // R6
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (dump_o && !clear_i) |=> ($stable(viol_ch_o) && $stable(viol_rs_o))); // R7
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    dump_o |-> ((int'(viol_ch_o) < N_CH) && (int'(viol_rs_o) < N_RS))); // R4
  AST_NO_OLD_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    ((chg || chg_d) && !dump_o) |=> !dump_o); // R8

endmodule

bind elvl_thr_cmp elvl_thr_cmp_chk #(
  .N_CH(N_CH), .N_RS(N_RS), .CH_W(CH_W), .RS_W(RS_W), .LVL_W(LVL_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .clear_i   (clear_i),
  .lvl_i     (lvl_i),
  .dump_o    (dump_o),
  .viol_ch_o (viol_ch_o),
  .viol_rs_o (viol_rs_o)
);

// File: tb/test_elvl_thr_cmp.sv
module test_elvl_thr_cmp;

  localparam int N_CH = 16, N_RS = 12, N_LVL = 32, SUM_W = 20;
  localparam int N_SLOT = N_CH * N_RS;
  localparam int SETTLE = 2 * N_SLOT + 8;
  localparam logic [SUM_W-1:0] TMAX = '1;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [N_SLOT*SUM_W-1:0] sums = '0;
  logic [4:0]              lvl = '0;
  logic                    clear = 1'b0;
  logic                    tw_en = 1'b0;
  logic [3:0]              tw_ch = '0;
  logic [3:0]              tw_rs = '0;
  logic [4:0]              tw_lvl = '0;
  logic [SUM_W-1:0]        tw_data = '0;
  logic                    dump;
  logic [3:0]              vch;
  logic [3:0]              vrs;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    dump;
    int    ch;
    int    rs;
    bit    chk_idx;
    string req;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  elvl_thr_cmp i_elvl_thr_cmp (
    .clk_i(clk), .rst_i(rst), .sums_i(sums), .lvl_i(lvl), .clear_i(clear),
    .tw_en_i(tw_en), .tw_ch_i(tw_ch), .tw_rs_i(tw_rs), .tw_lvl_i(tw_lvl),
    .tw_data_i(tw_data), .dump_o(dump), .viol_ch_o(vch), .viol_rs_o(vrs)
  );

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (dump !== e.dump) begin
          errors++;
          $display("FAIL %s: dump actual %0b expected %0b", e.req, dump, e.dump);
        end else if (e.chk_idx && (int'(vch) != e.ch || int'(vrs) != e.rs)) begin
          errors++;
          $display("FAIL %s: index actual (%0d,%0d) expected (%0d,%0d)",
                   e.req, vch, vrs, e.ch, e.rs);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic expect_out(input bit d, input int c, input int r, input bit ci,
                            input string req);
    exp_t e;
    e.dump = d; e.ch = c; e.rs = r; e.chk_idx = ci; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_thr(input int c, input int r, input int l, input int v);
    @(negedge clk);
    tw_en = 1'b1; tw_ch = 4'(c); tw_rs = 4'(r); tw_lvl = 5'(l); tw_data = SUM_W'(v);
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic set_sum(input int c, input int r, input int v);
    @(negedge clk);
    sums[(c * N_RS + r) * SUM_W +: SUM_W] = SUM_W'(v);
  endtask

  task automatic set_lvl(input int l);
    @(negedge clk);
    lvl = 5'(l);
  endtask

  task automatic do_clear();
    repeat (3) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out(1'b0, 0, 0, 1'b1, "R9 reset state");

    // fill the whole table with the largest threshold
    for (int l = 0; l < N_LVL; l++)
      for (int c = 0; c < N_CH; c++)
        for (int r = 0; r < N_RS; r++) begin
          @(negedge clk);
          tw_en = 1'b1; tw_ch = 4'(c); tw_rs = 4'(r); tw_lvl = 5'(l); tw_data = TMAX;
        end
    @(negedge clk);
    tw_en = 1'b0;
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R1 all-max table gives no request");

    // R2: strict comparison at level 3
    set_lvl(3);
    wr_thr(2, 4, 3, 100);
    set_sum(2, 4, 100);
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R2 equal sum does not trip");
    set_sum(2, 4, 101);
    settle();
    expect_out(1'b1, 2, 4, 1'b1, "R2 sum one above trips, R5 within window");

    // R6: sticky then clear
    set_sum(2, 4, 0);
    settle();
    expect_out(1'b1, 2, 4, 1'b1, "R6 request stays after sum drops");
    do_clear();
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R6 clear removes request");

    // R3: other level's threshold has no effect
    wr_thr(2, 4, 7, 50);
    set_sum(2, 4, 60);
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R3 level-7 limit ignored at level 3");
    set_lvl(7);
    settle();
    expect_out(1'b1, 2, 4, 1'b1, "R3 level-7 limit applies at level 7");
    set_sum(2, 4, 0);
    set_lvl(3);
    do_clear();
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R3 back at level 3 quiet");

    // R1: out-of-range sum index must not alias onto (1,1)
    wr_thr(0, 13, 3, 1);
    set_sum(1, 1, 5);
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R1 write with index 13 ignored");
    set_sum(1, 1, 0);

    // R4: both ends of the packed vector
    wr_thr(15, 11, 3, 7);
    set_sum(15, 10, 8);
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R4 neighbour field with max limit quiet");
    set_sum(15, 10, 0);
    set_sum(15, 11, 8);
    settle();
    expect_out(1'b1, 15, 11, 1'b1, "R4 last pair detected");
    set_sum(15, 11, 0);
    do_clear();
    wr_thr(0, 0, 3, 7);
    set_sum(0, 0, 8);
    settle();
    expect_out(1'b1, 0, 0, 1'b1, "R4 first pair detected");
    set_sum(0, 0, 0);
    do_clear();
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R6 quiet after second clear");

    // R7: first violation after a restart, later one not overwriting
    wr_thr(3, 5, 9, 10);
    wr_thr(9, 2, 9, 10);
    set_sum(3, 5, 20);
    set_sum(9, 2, 20);
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R3 level-9 limits unused at level 3");
    set_lvl(9);
    settle();
    expect_out(1'b1, 3, 5, 1'b1, "R7 first violation captured, R8 restart");
    set_sum(3, 5, 0);
    do_clear();
    settle();
    expect_out(1'b1, 9, 2, 1'b1, "R7 capture after clear");
    set_sum(9, 2, 0);
    do_clear();
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R7 quiet after clear");

    // R8: one-cycle excursion to a violating level
    wr_thr(6, 6, 12, 5);
    set_sum(6, 6, 10);
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R3 level-12 limit unused at level 9");
    @(negedge clk);
    lvl = 5'd12;
    @(negedge clk);
    lvl = 5'd9;
    settle();
    expect_out(1'b0, 0, 0, 1'b0, "R8 no request from discarded level read");
    set_lvl(12);
    settle();
    expect_out(1'b1, 6, 6, 1'b1, "R8 level 12 held trips");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule